// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block turns one multi-register load into a train of single memory reads and register-file writes. It handles two operations. The first is a word-multiple load, which fills the registers from a chosen first index up to the highest register. The second is a quadword load, which fills an aligned even/odd register pair from two doublewords. The caller supplies a one-cycle start pulse, the operation, the first register index, the starting effective address and the endianness mode. Effective-address arithmetic happens upstream and is not part of this block.

Reads go out one at a time on a simple request/response interface. The block raises a one-cycle request carrying an address and a byte size. It then waits for a response with valid data and writes the register in that same cycle. Word beats are zero-extended into the register. In little-endian mode, quadword beats are byte-reversed and go to the opposite register of the pair. A quadword load with an odd first register is rejected with no memory or register activity.

Top module: `mrl_seq`

## Requirements
- R1: After reset, busy_o, done_o, illegal_o, req_valid_o and rf_we_o are all 0.
- R2: A word-multiple load (op_i = 0) with first index rt_i writes registers rt_i, rt_i+1, ... up to 31 in ascending order, one per response, so 32-rt_i writes in total; rt_i = 31 gives exactly one write.
- R3: Word-multiple requests have req_size_o = 4, the first at ea_i and each next one 4 bytes higher; each written value has rsp_data_i[31:0] in its low 32 bits and zeros in its upper 32 bits.
- R4: A quadword load (op_i = 1) with even rt_i and le_i = 0 requests 8 bytes at ea_i and then at ea_i+8; the first doubleword goes to register rt_i and the second to rt_i+1, unchanged.
- R5: With le_i = 1 the same two requests are made, but the doubleword from ea_i goes to rt_i+1 and the one from ea_i+8 goes to rt_i, each with its 8 bytes in reversed order (byte 0 = bits 7:0 swaps with byte 7 = bits 63:56, and so on).
- R6: A quadword start with odd rt_i raises illegal_o for one cycle, in the cycle after the start, and makes no request and no write; busy_o stays 0.
- R7: req_valid_o is a one-cycle pulse, and no new request is issued until the previous one has been answered; a rsp_valid_i while no request is pending causes no write.
- R8: rf_we_o rises in exactly the cycle in which rsp_valid_i answers the pending request, once per request.
- R9: busy_o is 1 from the cycle after an accepted start through the done cycle; done_o is a one-cycle pulse in the cycle after the final register write.
- R10: start_i is ignored while busy_o is 1, including in the cycle of the final register write and in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_i | input | 1 | 0 = word-multiple load, 1 = quadword load |
| rt_i | input | 5 | First destination register index |
| ea_i | input | 32 | Starting effective address |
| le_i | input | 1 | 1 = little-endian mode |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data, right-aligned for 4-byte reads |
| req_valid_o | output | 1 | Read request pulse |
| req_addr_o | output | 32 | Read address |
| req_size_o | output | 4 | Read size in bytes (4 or 8) |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Register write index |
| rf_data_o | output | 64 | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle pulse for a rejected odd-pair quadword start |

## Verification
The final register write of an operation and a fresh start request can land in the same cycle. In that cycle the sequencer is still busy, so it must finish the old operation and drop the new one. The bench provokes this by having its memory responder raise start_i in the very cycle it returns the last beat of a single-transfer load. The run passes if exactly one register write, one request and one done pulse appear, and no further request follows in the idle cycles after.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic {
    OP_LMW = 1'b0,
    OP_LQ  = 1'b1
  } mrl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } mrl_st_e;
endpackage

// File: rtl/mrl_ctrl.sv
module mrl_ctrl
  import mrl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 32,
  parameter int WSTEP = 4,
  parameter int QSTEP = 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_i,
  input  logic [RW-1:0] rt_i,
  input  logic [AW-1:0] ea_i,
  input  logic          le_i,
  input  logic          rsp_valid_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  output logic          req_quad_o,
  output logic          beat_we_o,
  output mrl_op_e       op_o,
  output logic          le_o,
  output logic [RW-1:0] rt_o,
  output logic [RW-1:0] idx_o,
  output logic          beat_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o
);
  mrl_st_e       st_q, st_d;
  mrl_op_e       op_q;
  logic          le_q, beat_q, ill_q;
  logic [RW-1:0] rt_q, idx_q;
  logic [AW-1:0] addr_q;
  logic          last_beat, accept, odd_pair;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign odd_pair  = (mrl_op_e'(op_i) == OP_LQ) && rt_i[0];
  assign last_beat = (op_q == OP_LMW) ? (idx_q == RW'(NREG - 1)) : beat_q;
  assign beat_we_o = (st_q == ST_WAIT) && rsp_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept && !odd_pair) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) st_d = last_beat ? ST_FIN : ST_ISSUE;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_LMW;
      le_q   <= 1'b0;
      beat_q <= 1'b0;
      ill_q  <= 1'b0;
      rt_q   <= '0;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q  <= st_d;
      ill_q <= accept && odd_pair;
      if (accept && !odd_pair) begin
        op_q   <= mrl_op_e'(op_i);
        le_q   <= le_i;
        rt_q   <= rt_i;
        idx_q  <= rt_i;
        addr_q <= ea_i;
        beat_q <= 1'b0;
      end else if (beat_we_o && !last_beat) begin
        idx_q  <= idx_q + 1'b1;
        beat_q <= ~beat_q;
        addr_q <= addr_q + AW'((op_q == OP_LQ) ? QSTEP : WSTEP);
      end
    end
  end

  assign req_valid_o = (st_q == ST_ISSUE);
  assign req_addr_o  = addr_q;
  assign req_quad_o  = (op_q == OP_LQ);
  assign op_o        = op_q;
  assign le_o        = le_q;
  assign rt_o        = rt_q;
  assign idx_o       = idx_q;
  assign beat_o      = beat_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign illegal_o   = ill_q;

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  assert_no_req_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_we_o |-> !req_valid_o);
  assert_illegal_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!busy_o && !req_valid_o && !beat_we_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(beat_we_o));
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> busy_o);
endmodule

// File: rtl/mrl_fmt.sv
module mrl_fmt
  import mrl_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG),
  localparam int NB  = DW / 8,
  localparam int WW  = DW / 2
) (
  input  mrl_op_e       op_i,
  input  logic          le_i,
  input  logic          beat_i,
  input  logic [RW-1:0] rt_i,
  input  logic [RW-1:0] idx_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [RW-1:0] rf_idx_o,
  output logic [DW-1:0] rf_data_o
);
  logic [DW-1:0] rev;

  for (genvar g = 0; g < NB; g++) begin : g_rev
    assign rev[g*8 +: 8] = rsp_data_i[(NB-1-g)*8 +: 8];
  end

  always_comb begin
    if (op_i == OP_LMW) begin
      rf_idx_o  = idx_i;
      rf_data_o = {{(DW-WW){1'b0}}, rsp_data_i[WW-1:0]};
    end else begin
      // little-endian swaps which half of the pair each beat lands in
      rf_idx_o  = {rt_i[RW-1:1], beat_i ^ le_i};
      rf_data_o = le_i ? rev : rsp_data_i;
    end
  end
endmodule

// File: rtl/mrl_seq.sv
module mrl_seq
  import mrl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG),
  localparam int SZW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           op_i,
  input  logic [RW-1:0]  rt_i,
  input  logic [AW-1:0]  ea_i,
  input  logic           le_i,
  input  logic           rsp_valid_i,
  input  logic [DW-1:0]  rsp_data_i,
  output logic           req_valid_o,
  output logic [AW-1:0]  req_addr_o,
  output logic [SZW-1:0] req_size_o,
  output logic           rf_we_o,
  output logic [RW-1:0]  rf_idx_o,
  output logic [DW-1:0]  rf_data_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           illegal_o
);
  localparam int QBYTES = DW / 8;
  localparam int WBYTES = DW / 16;

  mrl_op_e       op_w;
  logic          le_w, beat_w, quad_w;
  logic [RW-1:0] rt_w, idx_w;

  mrl_ctrl #(
    .AW(AW), .NREG(NREG), .WSTEP(WBYTES), .QSTEP(QBYTES)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .rt_i(rt_i), .ea_i(ea_i), .le_i(le_i), .rsp_valid_i(rsp_valid_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_quad_o(quad_w),
    .beat_we_o(rf_we_o), .op_o(op_w), .le_o(le_w), .rt_o(rt_w),
    .idx_o(idx_w), .beat_o(beat_w), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o)
  );

  mrl_fmt #(.DW(DW), .NREG(NREG)) u_fmt (
    .op_i(op_w), .le_i(le_w), .beat_i(beat_w), .rt_i(rt_w), .idx_i(idx_w),
    .rsp_data_i(rsp_data_i), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o)
  );

  assign req_size_o = SZW'(quad_w ? QBYTES : WBYTES);

  assert_lq_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && quad_w) |-> (rf_idx_o[RW-1:1] == rt_w[RW-1:1]));
  assert_lmw_zext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !quad_w) |-> (rf_data_o[DW-1:DW/2] == '0));
endmodule

// File: tb/sim_mrl_seq.sv
`timescale 1ns/1ps
module sim_mrl_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, op_i = 1'b0, le_i = 1'b0;
  logic [4:0]  rt_i = '0;
  logic [31:0] ea_i = '0;
  logic        rsp_valid_i;
  logic [63:0] rsp_data_i;
  logic        req_valid_o, rf_we_o, busy_o, done_o, illegal_o;
  logic [31:0] req_addr_o;
  logic [3:0]  req_size_o;
  logic [4:0]  rf_idx_o;
  logic [63:0] rf_data_o;

  always #5 clk_i = ~clk_i;

  mrl_seq u0 (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0, w_n = 0, r_n = 0, rsp_n = 0, done_n = 0, ill_n = 0;
  int done_cyc = 0, last_wcyc = 0, viol = 0;
  logic        outst = 1'b0;
  logic [4:0]  w_idx [64];
  logic [63:0] w_dat [64];
  logic [31:0] r_addr[64];
  logic [3:0]  r_size[64];
  int          mem_lat = 1, stray_n = 0;
  logic        collide = 1'b0;

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction
  function automatic logic [63:0] dword_at(logic [31:0] a);
    return {word_at(a), word_at(a + 32'd4)};
  endfunction
  function automatic logic [63:0] swap8(logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // monitor, sampled mid-cycle
  always @(negedge clk_i) begin
    cyc++;
    if (rf_we_o) begin
      if (w_n < 64) begin w_idx[w_n] = rf_idx_o; w_dat[w_n] = rf_data_o; end
      w_n++; last_wcyc = cyc;
      if (!rsp_valid_i) viol++;
      outst = 1'b0;
    end
    if (req_valid_o) begin
      if (outst) viol++;
      if (r_n < 64) begin r_addr[r_n] = req_addr_o; r_size[r_n] = req_size_o; end
      r_n++; outst = 1'b1;
    end
    if (done_o) begin done_n++; done_cyc = cyc; end
    if (illegal_o) ill_n++;
  end

  // memory responder, drives just after the rising edge
  initial begin
    int cnt = 0;
    logic [63:0] pend = '0;
    logic clr = 1'b0;
    rsp_valid_i = 1'b0; rsp_data_i = '0;
    forever begin
      @(posedge clk_i); #1;
      rsp_valid_i = 1'b0;
      if (clr) begin start_i = 1'b0; clr = 1'b0; end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rsp_valid_i = 1'b1; rsp_data_i = pend; rsp_n++;
          if (collide) begin
            start_i = 1'b1; op_i = 1'b1; rt_i = 5'd4; ea_i = 32'h500;
            collide = 1'b0; clr = 1'b1;
          end
        end
      end else if (req_valid_o) begin
        cnt  = mem_lat;
        pend = (req_size_o == 4'd8) ? dword_at(req_addr_o)
                                    : {32'hDEAD_BEEF, word_at(req_addr_o)};
      end else if (stray_n > 0) begin
        rsp_valid_i = 1'b1; rsp_data_i = 64'hBAD0_BAD0_BAD0_BAD0; stray_n--;
      end
    end
  end

  task automatic clr_log();
    w_n = 0; r_n = 0; rsp_n = 0; done_n = 0; ill_n = 0; viol = 0;
  endtask

  task automatic run_op(logic op, logic [4:0] rt, logic [31:0] ea, logic le, int lat, bit legal);
    clr_log(); mem_lat = lat;
    @(posedge clk_i); #1;
    start_i = 1'b1; op_i = op; rt_i = rt; ea_i = ea; le_i = le;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    @(negedge clk_i);
    if (legal) chk(busy_o == 1'b1, "R9", "busy after start", 64'(busy_o), 64'd1);
    else begin
      chk(illegal_o == 1'b1, "R6", "illegal pulse", 64'(illegal_o), 64'd1);
      chk(busy_o == 1'b0, "R6", "busy on odd pair", 64'(busy_o), 64'd0);
    end
    for (int t = 0; t < 3000 && busy_o; t++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_common(int n, string rq);
    chk(w_n == n, rq, "write count", 64'(w_n), 64'(n));
    chk(r_n == n, "R7", "request count", 64'(r_n), 64'(n));
    chk(viol == 0, "R7", "overlap or unanswered write", 64'(viol), 64'd0);
    chk(rsp_n == w_n, "R8", "writes per response", 64'(w_n), 64'(rsp_n));
    chk(done_n == 1, "R9", "done pulses", 64'(done_n), 64'd1);
    chk(done_cyc == last_wcyc + 1, "R9", "done timing", 64'(done_cyc), 64'(last_wcyc + 1));
  endtask

  task automatic t_lmw(logic [4:0] rt, logic [31:0] ea, int lat);
    int n = 32 - int'(rt);
    run_op(1'b0, rt, ea, 1'b0, lat, 1'b1);
    check_common(n, "R2");
    for (int k = 0; k < n; k++) begin
      chk(w_idx[k] == 5'(int'(rt) + k), "R2", "lmw index", 64'(w_idx[k]), 64'(int'(rt) + k));
      chk(w_dat[k] == {32'h0, word_at(ea + 32'(4 * k))}, "R3", "lmw data",
          w_dat[k], {32'h0, word_at(ea + 32'(4 * k))});
      chk(r_addr[k] == ea + 32'(4 * k) && r_size[k] == 4'd4, "R3", "lmw request",
          {28'h0, r_size[k], r_addr[k]}, {32'h4, ea + 32'(4 * k)});
    end
  endtask

  task automatic t_lq(logic [4:0] rt, logic [31:0] ea, logic le, int lat);
    string rq = le ? "R5" : "R4";
    logic [4:0]  e_idx0 = le ? rt + 5'd1 : rt;
    logic [4:0]  e_idx1 = le ? rt : rt + 5'd1;
    logic [63:0] e_d0 = le ? swap8(dword_at(ea)) : dword_at(ea);
    logic [63:0] e_d1 = le ? swap8(dword_at(ea + 32'd8)) : dword_at(ea + 32'd8);
    run_op(1'b1, rt, ea, le, lat, 1'b1);
    check_common(2, rq);
    chk(r_addr[0] == ea && r_size[0] == 4'd8, rq, "first request",
        {28'h0, r_size[0], r_addr[0]}, {32'h8, ea});
    chk(r_addr[1] == ea + 32'd8 && r_size[1] == 4'd8, rq, "second request",
        {28'h0, r_size[1], r_addr[1]}, {32'h8, ea + 32'd8});
    chk(w_idx[0] == e_idx0, rq, "first index", 64'(w_idx[0]), 64'(e_idx0));
    chk(w_dat[0] == e_d0, rq, "first data", w_dat[0], e_d0);
    chk(w_idx[1] == e_idx1, rq, "second index", 64'(w_idx[1]), 64'(e_idx1));
    chk(w_dat[1] == e_d1, rq, "second data", w_dat[1], e_d1);
  endtask

  task automatic t_odd();
    run_op(1'b1, 5'd5, 32'h240, 1'b0, 1, 1'b0);
    chk(ill_n == 1, "R6", "illegal count", 64'(ill_n), 64'd1);
    chk(w_n == 0 && r_n == 0, "R6", "no activity", 64'(w_n + r_n), 64'd0);
  endtask

  task automatic t_stray();
    clr_log(); stray_n = 3;
    repeat (6) @(negedge clk_i);
    chk(w_n == 0, "R7", "stray response write", 64'(w_n), 64'd0);
    chk(busy_o == 1'b0, "R7", "stray response busy", 64'(busy_o), 64'd0);
  endtask

  task automatic t_busy_start();
    fork
      run_op(1'b0, 5'd30, 32'h600, 1'b0, 3, 1'b1);
      begin
        repeat (4) @(posedge clk_i); #1;
        start_i = 1'b1; op_i = 1'b1; rt_i = 5'd2;
        @(posedge clk_i); #1;
        start_i = 1'b0;
      end
    join
    chk(w_n == 2, "R10", "writes with mid start", 64'(w_n), 64'd2);
    chk(w_idx[1] == 5'd31, "R10", "last index", 64'(w_idx[1]), 64'd31);
  endtask

  task automatic t_collide();
    collide = 1'b1;
    run_op(1'b0, 5'd31, 32'h300, 1'b0, 2, 1'b1);
    repeat (4) @(negedge clk_i);
    chk(w_n == 1, "R10", "collision writes", 64'(w_n), 64'd1);
    chk(r_n == 1, "R10", "collision requests", 64'(r_n), 64'd1);
    chk(done_n == 1, "R10", "collision done", 64'(done_n), 64'd1);
    chk(busy_o == 1'b0, "R10", "collision busy", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, done_o, illegal_o, req_valid_o, rf_we_o} == 5'b0, "R1", "reset outputs",
        64'({busy_o, done_o, illegal_o, req_valid_o, rf_we_o}), 64'd0);
    t_lmw(5'd28, 32'h100, 1);
    t_lmw(5'd31, 32'h1F0, 2);
    t_lmw(5'd0, 32'h400, 3);
    t_lq(5'd6, 32'h200, 1'b0, 1);
    t_lq(5'd10, 32'h280, 1'b1, 2);
    t_odd();
    t_stray();
    t_busy_start();
    t_collide();
    t_lq(5'd30, 32'h700, 1'b1, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule